// File: doc/BRIEF.md
# Temperature Sensor Configure-and-Read Sequencer

This block sits in front of a byte-level two-wire bus master and drives that master's command port. It runs a fixed script against a temperature sensor on the bus. On the first start after reset it sets the sensor to 12-bit resolution, then selects the temperature register, then reads it. On every later start it runs only the read. The master's `busy` output goes low at each byte acknowledge. The sequencer treats each such falling edge as a handoff. At that point it either presents the next byte of the script, or it drops the enable so that the master ends the transaction.

A completed read yields two bytes. The sequencer keeps the upper 12 bits of the 16-bit value and presents them as `temp_data` with a one-cycle `temp_valid` strobe. There is no back-pressure on this output. The consumer must take the word in the strobe cycle, and the word holds its value until the next strobe. If the master reports a missing acknowledge, the script stops, the enable drops and `err_flag` rises.

Top module: `tsense_seq`

## Requirements
- R1: During and right after reset, `mst_ena`, `temp_valid` and `err_flag` are low and `temp_data` is zero.
- R2: The first accepted start opens a write transaction to address 7'b1001000 with `mst_rnw`=0. It sends byte 0x01 and then byte 0x60, and drops `mst_ena` after the second byte's acknowledge. `mst_wdata` changes only while `mst_busy` is low.
- R3: Once that transaction has ended, a second write transaction sends the single byte 0x00 and then ends.
- R4: Next comes a transaction with `mst_rnw`=1. `mst_ena` stays high across the first byte's handoff, so a second byte is read. It drops at the second byte's handoff, so the master NACKs and stops. `mst_rnw` holds steady while `mst_ena` stays high.
- R5: After the read transaction's final `busy` fall, `temp_valid` is high for exactly one cycle. `temp_data` then equals {first byte, upper four bits of second byte}.
- R6: After one error-free run of the full script, each further start performs only the read transaction.
- R7: A start is accepted only while the sequencer is idle and `mst_busy` is low. `mst_ena` never rises in the cycle after one where `mst_busy` was high.
- R8: If `mst_ack_err` is high once the master has taken the current command, the sequence aborts. `mst_ena` drops, `err_flag` is set, no valid strobe follows and the sequencer returns to idle.
- R9: `err_flag` stays set until the next accepted start clears it. If the configuration had not completed, that start runs the full script again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the script |
| mst_busy | input | 1 | Master busy; a falling edge marks a byte handoff |
| mst_ack_err | input | 1 | Master missing-acknowledge flag |
| mst_rdata | input | 8 | Byte last read by the master |
| mst_ena | output | 1 | Command enable to the master |
| mst_addr | output | 7 | Target bus address |
| mst_rnw | output | 1 | 1 = read, 0 = write |
| mst_wdata | output | 8 | Byte to write |
| temp_data | output | 12 | Latest temperature word |
| temp_valid | output | 1 | One-cycle strobe for a new word |
| err_flag | output | 1 | Sticky abort indicator |

## Verification
The hardest case to reach from the ports is a missing acknowledge that arrives while `busy` is already low at a data-byte handoff. A stale error left over from an earlier failure must not abort the next run, while this fresh one must. The bench's command-level master model can raise the error either at the address phase of a read or at the handoff of a chosen write byte (0x60). It then issues a clean start while the stale flag is still asserted. A second start pulsed in the middle of a read transaction covers the case where a start must be ignored.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DRAIN} seq_state_t;
  typedef enum logic [1:0] {TX_CONFIG, TX_POINT, TX_READ} txn_t;
  typedef struct packed {
    logic       rnw;
    logic [7:0] wdata;
    logic       last;
  } step_t;
endpackage

// File: rtl/tsense_script.sv
module tsense_script
  import tsense_pkg::*;
#(
  parameter logic [7:0] CFG_PTR  = 8'h01,
  parameter logic [7:0] CFG_VAL  = 8'h60,
  parameter logic [7:0] TEMP_PTR = 8'h00
) (
  input  txn_t  txn,
  input  logic  byte_idx,
  output step_t step
);
  always_comb begin
    step.rnw   = 1'b0;
    step.wdata = 8'h00;
    step.last  = 1'b1;
    case (txn)
      TX_CONFIG: begin
        step.wdata = byte_idx ? CFG_VAL : CFG_PTR;
        step.last  = byte_idx;
      end
      TX_POINT: begin
        step.wdata = TEMP_PTR;
      end
      TX_READ: begin
        step.rnw  = 1'b1;
        step.last = byte_idx;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsense_fall.sv
module tsense_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  logic level_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  assign fall = level_q & ~level;
endmodule

// File: rtl/tsense_word.sv
module tsense_word #(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic              publish,
  input  logic [7:0]        rdata,
  output logic [TEMP_W-1:0] word,
  output logic              valid
);
  localparam int RAW_W = 16;
  logic [7:0] hi_q, lo_q;
  logic [RAW_W-1:0] raw;
  assign raw = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      if (cap_hi) hi_q <= rdata;
      if (cap_lo) lo_q <= rdata;
      valid <= publish;
      if (publish) word <= raw[RAW_W-1 -: TEMP_W];
    end
  end
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
  import tsense_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter logic [7:0] CFG_PTR  = 8'h01,
  parameter logic [7:0] CFG_VAL  = 8'h60,
  parameter logic [7:0] TEMP_PTR = 8'h00,
  parameter int         TEMP_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mst_busy,
  input  logic              mst_ack_err,
  input  logic [7:0]        mst_rdata,
  output logic              mst_ena,
  output logic [6:0]        mst_addr,
  output logic              mst_rnw,
  output logic [7:0]        mst_wdata,
  output logic [TEMP_W-1:0] temp_data,
  output logic              temp_valid,
  output logic              err_flag
);
  seq_state_t state;
  txn_t       txn;
  logic       byte_idx, ena_q, cfg_done, err_q, seen_busy;
  logic       busy_fall, abort;
  step_t      step;

  tsense_script #(.CFG_PTR(CFG_PTR), .CFG_VAL(CFG_VAL), .TEMP_PTR(TEMP_PTR)) u_script (
    .txn(txn), .byte_idx(byte_idx), .step(step));

  tsense_fall u_fall (.clk(clk), .rst_n(rst_n), .level(mst_busy), .fall(busy_fall));

  // an error only counts once the master has taken this transaction's command
  assign abort = (state != ST_IDLE) && seen_busy && mst_ack_err;

  logic in_read, cap_hi, cap_lo, publish;
  assign in_read = (txn == TX_READ);
  assign cap_hi  = (state == ST_XFER)  && busy_fall && in_read && !byte_idx && !abort;
  assign cap_lo  = (state == ST_XFER)  && busy_fall && in_read &&  byte_idx && !abort;
  assign publish = (state == ST_DRAIN) && busy_fall && in_read && !abort;

  tsense_word #(.TEMP_W(TEMP_W)) u_word (
    .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .cap_lo(cap_lo), .publish(publish),
    .rdata(mst_rdata), .word(temp_data), .valid(temp_valid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      txn       <= TX_CONFIG;
      byte_idx  <= 1'b0;
      ena_q     <= 1'b0;
      cfg_done  <= 1'b0;
      err_q     <= 1'b0;
      seen_busy <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start && !mst_busy) begin
        err_q     <= 1'b0;
        txn       <= cfg_done ? TX_READ : TX_CONFIG;
        byte_idx  <= 1'b0;
        ena_q     <= 1'b1;
        seen_busy <= 1'b0;
        state     <= ST_XFER;
      end
    end else if (abort) begin
      ena_q <= 1'b0;
      err_q <= 1'b1;
      state <= ST_IDLE;
    end else begin
      if (mst_busy) seen_busy <= 1'b1;
      if (busy_fall) begin
        if (state == ST_XFER) begin
          if (step.last) begin
            ena_q <= 1'b0;
            state <= ST_DRAIN;
          end else begin
            byte_idx <= 1'b1;
          end
        end else if (in_read) begin
          state <= ST_IDLE;
        end else begin
          if (txn == TX_POINT) cfg_done <= 1'b1;
          txn       <= txn_t'(txn + 2'd1);
          byte_idx  <= 1'b0;
          ena_q     <= 1'b1;
          seen_busy <= 1'b0;
          state     <= ST_XFER;
        end
      end
    end
  end

  assign mst_ena   = ena_q;
  assign mst_addr  = DEV_ADDR;
  assign mst_rnw   = step.rnw;
  assign mst_wdata = step.wdata;
  assign err_flag  = err_q;
endmodule

// File: rtl/tsense_chk.sv
module tsense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mst_busy,
  input logic       mst_ena,
  input logic       mst_rnw,
  input logic [7:0] mst_wdata,
  input logic       temp_valid,
  input logic       err_flag
);
  // R2
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_busy && $past(mst_busy) |-> $stable(mst_wdata));
  // R4
  rnw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ena && $past(mst_ena) |-> $stable(mst_rnw));
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |=> !temp_valid);
  // R7
  ena_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_ena) |-> !$past(mst_busy));
  // R8
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !mst_ena);
  // R8
  err_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |-> !err_flag);
endmodule

bind tsense_seq tsense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_busy(mst_busy), .mst_ena(mst_ena),
  .mst_rnw(mst_rnw), .mst_wdata(mst_wdata), .temp_valid(temp_valid), .err_flag(err_flag));

// File: tb/sim_tsense_seq.sv
module sim_tsense_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy = 1'b0, ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic ena_o, rnw_o, valid_o, err_o;
  logic [6:0] addr_o;
  logic [7:0] wdata_o;
  logic [11:0] temp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsense_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mst_busy(busy), .mst_ack_err(ack),
    .mst_rdata(rdata), .mst_ena(ena_o), .mst_addr(addr_o), .mst_rnw(rnw_o),
    .mst_wdata(wdata_o), .temp_data(temp_o), .temp_valid(valid_o), .err_flag(err_o));

  int checks = 0, fails = 0;
  int txn_cnt, wcnt, rcnt, valid_cnt;
  logic [6:0] txn_addr [0:7];
  logic       txn_rnw  [0:7];
  logic [7:0] wlog     [0:15];
  logic [11:0] last_temp;
  logic [7:0] rd_hi = 8'h00, rd_lo = 8'h00, inj_byte = 8'h00, cur_w;
  logic inj_addr_nack = 1'b0, inj_data_nack = 1'b0;
  logic m_r, m_stop;
  int m_nb;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // command-level model of the byte master
  initial begin
    forever begin
      @(negedge clk);
      if (ena_o) begin
        m_r = rnw_o; ack = 1'b0; busy = 1'b1;
        if (txn_cnt < 8) begin txn_addr[txn_cnt] = addr_o; txn_rnw[txn_cnt] = m_r; end
        txn_cnt++;
        m_nb = 0; m_stop = 1'b0;
        repeat (GAP) @(negedge clk);
        if (m_r && inj_addr_nack) begin ack = 1'b1; m_stop = 1'b1; end
        while (!m_stop) begin
          cur_w = wdata_o;
          if (!m_r) begin
            if (wcnt < 16) wlog[wcnt] = cur_w;
            wcnt++;
          end
          repeat (GAP) @(negedge clk);
          busy = 1'b0;
          if (m_r) begin rdata = (m_nb == 0) ? rd_hi : rd_lo; rcnt++; end
          if (!m_r && inj_data_nack && cur_w == inj_byte) ack = 1'b1;
          m_nb++;
          repeat (GAP/2) @(negedge clk);
          if (ena_o) busy = 1'b1;
          else m_stop = 1'b1;
        end
        busy = 1'b1;
        repeat (3) @(negedge clk);
        busy = 1'b0;
      end
    end
  end

  always @(negedge clk) if (rst_n && valid_o) begin valid_cnt++; last_temp = temp_o; end

  task automatic clear_log();
    txn_cnt = 0; wcnt = 0; rcnt = 0; valid_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5000 && q < 20; i++) begin
      @(negedge clk);
      if (!ena_o && !busy) q++; else q = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; inj_addr_nack = 1'b0; inj_data_nack = 1'b0;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ena_o == 0, "R1 ena", ena_o, 0);
    chk(valid_o == 0 && err_o == 0, "R1 valid/err", {valid_o, err_o}, 0);
    chk(temp_o == 0, "R1 temp", temp_o, 0);
  endtask

  task automatic t_first_run();
    rd_hi = 8'h19; rd_lo = 8'h3A; clear_log();
    pulse_start(); wait_quiet();
    chk(txn_cnt == 3, "R2 transaction count", txn_cnt, 3);
    chk(txn_addr[0] == 7'h48 && txn_rnw[0] == 0, "R2 address/write", {txn_addr[0], txn_rnw[0]}, 8'h90);
    chk(wlog[0] == 8'h01 && wlog[1] == 8'h60, "R2 config bytes", {wlog[0], wlog[1]}, 16'h0160);
    chk(wcnt == 3 && wlog[2] == 8'h00 && txn_rnw[1] == 0, "R3 pointer write", wcnt, 3);
    chk(txn_rnw[2] == 1 && txn_addr[2] == 7'h48, "R4 read transaction", txn_rnw[2], 1);
    chk(rcnt == 2, "R4 read byte count", rcnt, 2);
    chk(valid_cnt == 1, "R5 valid cycles", valid_cnt, 1);
    chk(last_temp == 12'h193, "R5 temperature", last_temp, 12'h193);
    chk(err_o == 0, "R8 no error", err_o, 0);
  endtask

  task automatic t_repeat_read();
    rd_hi = 8'hE7; rd_lo = 8'h0F; clear_log();
    pulse_start(); wait_quiet();
    chk(txn_cnt == 1 && txn_rnw[0] == 1, "R6 read only", txn_cnt, 1);
    chk(wcnt == 0, "R6 no writes", wcnt, 0);
    chk(valid_cnt == 1 && last_temp == 12'hE70, "R5 second temperature", last_temp, 12'hE70);
  endtask

  task automatic t_start_ignored();
    rd_hi = 8'h7F; rd_lo = 8'hF0; clear_log();
    pulse_start();
    repeat (12) @(negedge clk);
    pulse_start();
    wait_quiet();
    chk(txn_cnt == 1, "R7 extra start ignored", txn_cnt, 1);
    chk(valid_cnt == 1 && last_temp == 12'h7FF, "R7 single result", last_temp, 12'h7FF);
  endtask

  task automatic t_addr_nack();
    rd_hi = 8'h12; rd_lo = 8'h34; clear_log(); inj_addr_nack = 1'b1;
    pulse_start(); wait_quiet();
    chk(err_o == 1, "R8 error on address NACK", err_o, 1);
    chk(valid_cnt == 0 && ena_o == 0, "R8 no valid, ena low", valid_cnt, 0);
    inj_addr_nack = 1'b0; clear_log();
    pulse_start(); wait_quiet();
    chk(err_o == 0, "R9 error cleared", err_o, 0);
    chk(txn_cnt == 1 && valid_cnt == 1 && last_temp == 12'h123, "R9 read after error", last_temp, 12'h123);
  endtask

  task automatic t_data_nack();
    do_reset();
    rd_hi = 8'hA5; rd_lo = 8'h5A; inj_data_nack = 1'b1; inj_byte = 8'h60;
    pulse_start(); wait_quiet();
    chk(err_o == 1, "R8 error on data NACK", err_o, 1);
    chk(txn_cnt == 1 && wcnt == 2 && valid_cnt == 0, "R8 script aborted", txn_cnt, 1);
    inj_data_nack = 1'b0; clear_log();
    pulse_start(); wait_quiet();
    chk(txn_cnt == 3 && err_o == 0, "R9 full script rerun", txn_cnt, 3);
    chk(valid_cnt == 1 && last_temp == 12'hA55, "R9 temperature after rerun", last_temp, 12'hA55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_run();
    t_repeat_read();
    t_start_ignored();
    t_addr_nack();
    t_data_nack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule